// File: doc/BRIEF.md
# Speculative Out-of-Order Store Buffer

This block sits between the retirement stage of a core and the write port of its first-level data cache. Stores that have already retired enter it as word entries holding an address, data and a byte-enable mask. Each entry also records whether the store retired inside a speculative region. Entries leave for the cache in whatever order the cache can take them best. A store whose line is present in the cache goes ahead of one that misses. Each waiting miss ages, and once its age reaches a fixed limit it overtakes the hits, so a miss cannot wait forever. Two stores to the same word always leave in program order.

While stores wait, younger loads read through the buffer. Each byte comes from the youngest buffered store that writes it. Incoming coherence requests are compared at line granularity against the speculative entries. A match raises a violation flag, which tells the core that another agent is about to observe or overwrite speculative state. A commit request is acknowledged only once no speculative entry remains. A one-cycle abort pulse drops every speculative entry together and keeps the ordinary ones.

The cache tag lookup, the coherence fabric and the load pipeline are outside the block. They are modelled by plain signals: a per-slot hit vector, a request/grant write port, a load word address and a snoop line address.

Top module: `spec_store_buffer`

## Requirements
- R1: After reset the buffer holds no entry: `st_ready` is 1, `wr_req` is 0, `ld_fwd_be` is 0 and `commit_ack` equals `commit_req`.
- R2: A store is taken on a clock edge where `st_valid` and `st_ready` are both 1. It goes into the lowest-numbered free slot (0 to DEPTH-1). `st_ready` is 0 whenever all DEPTH slots are valid, and a store offered then is dropped and never written to the cache.
- R3: Bit i of `line_hit` reports a cache hit for the entry in slot i. When no entry has aged, an issuable entry whose hit bit is 1 is issued before any issuable entry whose hit bit is 0.
- R4: Among entries of the same priority class (aged, hitting, or other), the oldest by insertion order is issued first.
- R5: Each entry counts the clock edges on which it is valid and its hit bit is 0, saturating at AGE_LIMIT. An issuable entry whose count has reached AGE_LIMIT is issued ahead of every hitting entry.
- R6: An entry is not issued while an older valid entry targets the same word (address bits above the byte offset), so same-word stores reach the cache in program order.
- R7: For the load word address, each byte lane i of `ld_fwd_data` comes from the youngest valid entry to that word whose byte enable i is 1, and `ld_fwd_be[i]` is set. Lanes that no entry writes read 0 with `ld_fwd_be[i]` clear.
- R8: `violation` is 1 exactly when `snp_valid` is 1 and some valid speculative entry has line address (address bits above the line offset) equal to `snp_line`. Non-speculative entries never raise it.
- R9: `commit_ack` is 1 exactly when `commit_req` is 1 and no valid speculative entry remains.
- R10: A one-cycle `abort` removes every speculative entry at the next edge. Non-speculative entries stay, keep forwarding and are written to the cache as usual.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| st_valid | input | 1 | Retired store offered |
| st_addr | input | ADDR_W | Store byte address (word aligned) |
| st_data | input | DATA_W | Store data |
| st_be | input | DATA_W/8 | Store byte enables |
| st_spec | input | 1 | Store retired inside a speculative region |
| st_ready | output | 1 | A slot is free |
| wr_req | output | 1 | An entry is presented to the cache |
| wr_addr | output | ADDR_W | Address of the presented entry |
| wr_data | output | DATA_W | Data of the presented entry |
| wr_be | output | DATA_W/8 | Byte enables of the presented entry |
| wr_grant | input | 1 | Cache accepts the presented entry this cycle |
| line_hit | input | DEPTH | Per-slot cache hit indication |
| ld_word | input | ADDR_W-log2(DATA_W/8) | Load word address |
| ld_fwd_data | output | DATA_W | Forwarded bytes |
| ld_fwd_be | output | DATA_W/8 | Lanes supplied by the buffer |
| snp_valid | input | 1 | Coherence request present |
| snp_line | input | ADDR_W-log2(LINE_BYTES) | Line address of the request |
| violation | output | 1 | Request hits speculative state |
| commit_req | input | 1 | Core asks to close the speculative region |
| commit_ack | output | 1 | No speculative entry remains |
| abort | input | 1 | Discard speculative entries |

## Verification
The bench goes after the issue order. It makes a hit overtake older misses, lets two misses age past a younger hit, and lines up a younger hitting store behind an older miss to the same word. A design with the priorities swapped, with no aging, or with no same-word blocking writes the cache in the wrong order, and the scoreboard catches it, including a stale final value at the shared word. Forwarding is checked with two stores that partially overlap the same word, where a wrong youngest-pick or a missing byte merge returns mixed-up lanes. The bench also offers a store into a full buffer, snoops a line held only by ordinary stores, and aborts with ordinary and speculative entries mixed. Those catch an overflowing slot, a violation raised for non-speculative data, and an abort that drops too much or too little.

// File: rtl/ssb_pkg.sv
// Package: shared types of the speculative store buffer.
// Assumes nothing; holds the issue class reported by the drain arbiter.
package ssb_pkg;

    // Priority class of the entry picked for the cache write port
    typedef enum logic [1:0] {
        CLS_NONE = 2'd0,
        CLS_AGED = 2'd1,
        CLS_HIT  = 2'd2,
        CLS_MISS = 2'd3
    } issue_cls_e;

endpackage

// File: rtl/ssb_order_matrix.sv
// Module: insertion-order matrix for the buffer slots.
// Bit [i][j] of `older` is 1 when slot i was filled before slot j.
// Assumes at most one slot is allocated per cycle; relations that involve
// invalid slots are meaningless and must be masked by the user.
module ssb_order_matrix #(
    parameter int DEPTH = 4
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             alloc_vec,
    output logic [DEPTH-1:0][DEPTH-1:0]  older
);

    // Mark a newly filled slot as younger than every other slot
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            older <= '0;
        end else begin
            for (int k = 0; k < DEPTH; k++) begin
                if (alloc_vec[k]) begin
                    for (int j = 0; j < DEPTH; j++) begin
                        older[j][k] <= (j != k);
                        older[k][j] <= 1'b0;
                    end
                end
            end
        end
    end

    // R4: the order relation never claims two slots are each older than the other
    for (genvar i = 0; i < DEPTH; i++) begin : g_row
        for (genvar j = 0; j < DEPTH; j++) begin : g_col
            a_r4_order_antisym: assert property (@(posedge clk) disable iff (!rst_n)
                !(older[i][j] && older[j][i]));
        end
    end

endmodule

// File: rtl/ssb_drain_arbiter.sv
// Module: picks the entry sent to the cache write port.
// Classes in falling priority: aged misses, hits, everything else;
// oldest first inside a class. Keeps one saturating age counter per slot.
// Assumes `eligible` is already masked by validity and same-word ordering.
module ssb_drain_arbiter
    import ssb_pkg::*;
#(
    parameter int DEPTH     = 4,
    parameter int AGE_LIMIT = 8
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [DEPTH-1:0]             alloc_vec,
    input  logic [DEPTH-1:0]             valid,
    input  logic [DEPTH-1:0]             eligible,
    input  logic [DEPTH-1:0]             hit,
    input  logic [DEPTH-1:0][DEPTH-1:0]  older,
    output logic [DEPTH-1:0]             issue_vec,
    output issue_cls_e                   issue_cls
);

    localparam int AGE_W = $clog2(AGE_LIMIT + 1);
    localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(AGE_LIMIT);

    logic [AGE_W-1:0] age [DEPTH];
    logic [DEPTH-1:0] aged_vec;
    logic [DEPTH-1:0] hit_vec;
    logic [DEPTH-1:0] pool;

    // Count the cycles each waiting entry spends missing, saturating
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) age[i] <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_vec[i])
                    age[i] <= '0;
                else if (valid[i] && !hit[i] && age[i] != AGE_MAX)
                    age[i] <= age[i] + AGE_W'(1);
            end
        end
    end

    // Sort issuable entries into classes and choose the active class
    always_comb begin
        for (int i = 0; i < DEPTH; i++) aged_vec[i] = eligible[i] && (age[i] == AGE_MAX);
        hit_vec = eligible & hit;
        if (|aged_vec) begin
            pool = aged_vec;
            issue_cls = CLS_AGED;
        end else if (|hit_vec) begin
            pool = hit_vec;
            issue_cls = CLS_HIT;
        end else if (|eligible) begin
            pool = eligible;
            issue_cls = CLS_MISS;
        end else begin
            pool = '0;
            issue_cls = CLS_NONE;
        end
    end

    // Pick the oldest member of the active class
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            issue_vec[i] = pool[i];
            for (int j = 0; j < DEPTH; j++)
                if (pool[j] && older[j][i]) issue_vec[i] = 1'b0;
        end
    end

    // R4: at most one entry is presented at a time
    a_r4_one_issue: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(issue_vec));

    // R5: an aged entry wins over hits
    a_r5_aged_first: assert property (@(posedge clk) disable iff (!rst_n)
        (|aged_vec) |-> (|(issue_vec & aged_vec)));

    // R3: without aged entries, a hit wins over a miss
    a_r3_hit_first: assert property (@(posedge clk) disable iff (!rst_n)
        (!(|aged_vec) && (|hit_vec)) |-> (|(issue_vec & hit)));

    // R5: counters never pass the limit
    for (genvar i = 0; i < DEPTH; i++) begin : g_age_chk
        a_r5_age_bound: assert property (@(posedge clk) disable iff (!rst_n)
            age[i] <= AGE_MAX);
    end

endmodule

// File: rtl/ssb_fwd_merge.sv
// Module: byte-wise store-to-load forwarding.
// Each byte lane takes the youngest valid entry to the load word that
// enables that lane. Assumes `older` orders all valid slots.
module ssb_fwd_merge #(
    parameter int DEPTH  = 4,
    parameter int WORD_W = 30,
    parameter int DATA_W = 32
) (
    input  logic                              clk,
    input  logic                              rst_n,
    input  logic [DEPTH-1:0]                  valid,
    input  logic [DEPTH-1:0][WORD_W-1:0]      word_q,
    input  logic [DEPTH-1:0][DATA_W-1:0]      data_q,
    input  logic [DEPTH-1:0][DATA_W/8-1:0]    be_q,
    input  logic [DEPTH-1:0][DEPTH-1:0]       older,
    input  logic [WORD_W-1:0]                 ld_word,
    output logic [DATA_W-1:0]                 fwd_data,
    output logic [DATA_W/8-1:0]               fwd_be
);

    localparam int BYTES = DATA_W / 8;

    logic [DEPTH-1:0] match;

    // Find entries to the load word
    always_comb begin
        for (int i = 0; i < DEPTH; i++) match[i] = valid[i] && (word_q[i] == ld_word);
    end

    // Per lane, keep the byte of the youngest enabling match
    always_comb begin
        logic youngest;
        fwd_data = '0;
        fwd_be   = '0;
        for (int b = 0; b < BYTES; b++) begin
            for (int i = 0; i < DEPTH; i++) begin
                youngest = match[i] && be_q[i][b];
                for (int j = 0; j < DEPTH; j++)
                    if (match[j] && be_q[j][b] && older[i][j]) youngest = 1'b0;
                if (youngest) begin
                    fwd_be[b] = 1'b1;
                    fwd_data[b*8 +: 8] = data_q[i][b*8 +: 8];
                end
            end
        end
    end

    // R7: an empty buffer supplies no lane
    a_r7_empty_no_fwd: assert property (@(posedge clk) disable iff (!rst_n)
        (valid == '0) |-> (fwd_be == '0));

endmodule

// File: rtl/spec_store_buffer.sv
// Module: speculative store buffer with out-of-order drain (top).
// Holds retired word stores with a speculative flag, drains them to the
// cache hit-first with aging, keeps same-word stores in order, forwards
// to loads, checks snoops against speculative entries, and drops
// speculative entries on abort. Assumes stores are word aligned and that
// the cache reports hits per slot on `line_hit`.
module spec_store_buffer
    import ssb_pkg::*;
#(
    parameter int DEPTH      = 4,
    parameter int ADDR_W     = 32,
    parameter int DATA_W     = 32,
    parameter int LINE_BYTES = 16,
    parameter int AGE_LIMIT  = 8,
    localparam int BYTES     = DATA_W / 8,
    localparam int WOFF      = $clog2(BYTES),
    localparam int LOFF      = $clog2(LINE_BYTES),
    localparam int WORD_W    = ADDR_W - WOFF,
    localparam int LINE_W    = ADDR_W - LOFF
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               st_valid,
    input  logic [ADDR_W-1:0]  st_addr,
    input  logic [DATA_W-1:0]  st_data,
    input  logic [BYTES-1:0]   st_be,
    input  logic               st_spec,
    output logic               st_ready,
    output logic               wr_req,
    output logic [ADDR_W-1:0]  wr_addr,
    output logic [DATA_W-1:0]  wr_data,
    output logic [BYTES-1:0]   wr_be,
    input  logic               wr_grant,
    input  logic [DEPTH-1:0]   line_hit,
    input  logic [WORD_W-1:0]  ld_word,
    output logic [DATA_W-1:0]  ld_fwd_data,
    output logic [BYTES-1:0]   ld_fwd_be,
    input  logic               snp_valid,
    input  logic [LINE_W-1:0]  snp_line,
    output logic               violation,
    input  logic               commit_req,
    output logic               commit_ack,
    input  logic               abort
);

    logic [DEPTH-1:0]               valid_q;
    logic [DEPTH-1:0]               spec_q;
    logic [DEPTH-1:0][ADDR_W-1:0]   addr_q;
    logic [DEPTH-1:0][DATA_W-1:0]   data_q;
    logic [DEPTH-1:0][BYTES-1:0]    be_q;
    logic [DEPTH-1:0][WORD_W-1:0]   word_q;
    logic [DEPTH-1:0][DEPTH-1:0]    older;

    logic [DEPTH-1:0] free_pick;
    logic [DEPTH-1:0] alloc_vec;
    logic [DEPTH-1:0] blocked;
    logic [DEPTH-1:0] eligible;
    logic [DEPTH-1:0] issue_vec;
    logic [DEPTH-1:0] drop_vec;
    logic             insert;
    logic             fire;
    issue_cls_e       issue_cls;

    assign st_ready = ~(&valid_q);
    assign insert   = st_valid && st_ready;

    // Choose the lowest free slot for an incoming store
    always_comb begin
        free_pick = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (!valid_q[i]) begin
                free_pick = '0;
                free_pick[i] = 1'b1;
            end
        end
        alloc_vec = insert ? free_pick : '0;
    end

    // Word address of each entry, shared by ordering and forwarding
    always_comb begin
        for (int i = 0; i < DEPTH; i++) word_q[i] = addr_q[i][ADDR_W-1:WOFF];
    end

    // Hold back entries that have an older store to the same word
    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            blocked[i] = 1'b0;
            for (int j = 0; j < DEPTH; j++)
                if (valid_q[j] && older[j][i] && word_q[j] == word_q[i]) blocked[i] = 1'b1;
        end
        eligible = valid_q & ~blocked;
    end

    ssb_order_matrix #(.DEPTH(DEPTH)) u_order (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_vec (alloc_vec),
        .older     (older)
    );

    ssb_drain_arbiter #(.DEPTH(DEPTH), .AGE_LIMIT(AGE_LIMIT)) u_arb (
        .clk       (clk),
        .rst_n     (rst_n),
        .alloc_vec (alloc_vec),
        .valid     (valid_q),
        .eligible  (eligible),
        .hit       (line_hit),
        .older     (older),
        .issue_vec (issue_vec),
        .issue_cls (issue_cls)
    );

    ssb_fwd_merge #(.DEPTH(DEPTH), .WORD_W(WORD_W), .DATA_W(DATA_W)) u_fwd (
        .clk      (clk),
        .rst_n    (rst_n),
        .valid    (valid_q),
        .word_q   (word_q),
        .data_q   (data_q),
        .be_q     (be_q),
        .older    (older),
        .ld_word  (ld_word),
        .fwd_data (ld_fwd_data),
        .fwd_be   (ld_fwd_be)
    );

    // Present the picked entry on the cache write port
    always_comb begin
        wr_addr = '0;
        wr_data = '0;
        wr_be   = '0;
        for (int i = 0; i < DEPTH; i++) begin
            if (issue_vec[i]) begin
                wr_addr = wr_addr | addr_q[i];
                wr_data = wr_data | data_q[i];
                wr_be   = wr_be | be_q[i];
            end
        end
    end

    assign wr_req   = |issue_vec;
    assign fire     = wr_req && wr_grant;
    assign drop_vec = fire ? issue_vec : '0;

    // Fill, retire and abort-clear the slot flags
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= '0;
            spec_q  <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_vec[i]) begin
                    valid_q[i] <= 1'b1;
                    spec_q[i]  <= st_spec;
                end else if (drop_vec[i] || (abort && spec_q[i])) begin
                    valid_q[i] <= 1'b0;
                    spec_q[i]  <= 1'b0;
                end
            end
        end
    end

    // Capture the payload of an accepted store
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            data_q <= '0;
            be_q   <= '0;
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                if (alloc_vec[i]) begin
                    addr_q[i] <= st_addr;
                    data_q[i] <= st_data;
                    be_q[i]   <= st_be;
                end
            end
        end
    end

    // Compare a snoop line against speculative entries
    always_comb begin
        violation = 1'b0;
        for (int i = 0; i < DEPTH; i++)
            if (snp_valid && valid_q[i] && spec_q[i] && addr_q[i][ADDR_W-1:LOFF] == snp_line)
                violation = 1'b1;
    end

    assign commit_ack = commit_req && !(|(valid_q & spec_q));

    // R2: a full buffer stays full unless an entry leaves
    a_r2_no_overflow: assert property (@(posedge clk) disable iff (!rst_n)
        ((&valid_q) && !fire && !abort) |=> (&valid_q));

    // R10: abort leaves no speculative entry behind
    a_r10_abort_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (abort && !(insert && st_spec)) |=> ((valid_q & spec_q) == '0));

    // R3: a presented entry always carries a class and a valid slot
    a_r3_issue_valid: assert property (@(posedge clk) disable iff (!rst_n)
        wr_req |-> ((issue_cls != CLS_NONE) && (|(issue_vec & valid_q))));

    // R6: a granted entry is never blocked by an older same-word store
    a_r6_word_order: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> ((issue_vec & blocked) == '0));

    // R8: no violation without a snoop
    a_r8_snoop_gated: assert property (@(posedge clk) disable iff (!rst_n)
        violation |-> snp_valid);

    // R9: acknowledge only when asked
    a_r9_ack_gated: assert property (@(posedge clk) disable iff (!rst_n)
        commit_ack |-> commit_req);

endmodule

// File: tb/spec_store_buffer_test.sv
// Bench: scoreboard of expected cache writes plus direct port checks.
module spec_store_buffer_test;

    localparam int CLK_PERIOD = 10;
    localparam int DEPTH = 4;
    localparam int AW = 32;
    localparam int DW = 32;
    localparam int LB = 16;
    localparam int AGE = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic st_valid = 1'b0;
    logic [AW-1:0] st_addr = '0;
    logic [DW-1:0] st_data = '0;
    logic [3:0] st_be = '0;
    logic st_spec = 1'b0;
    logic st_ready;
    logic wr_req;
    logic [AW-1:0] wr_addr;
    logic [DW-1:0] wr_data;
    logic [3:0] wr_be;
    logic wr_grant = 1'b0;
    logic [DEPTH-1:0] line_hit = '1;
    logic [AW-3:0] ld_word = '0;
    logic [DW-1:0] ld_fwd_data;
    logic [3:0] ld_fwd_be;
    logic snp_valid = 1'b0;
    logic [AW-5:0] snp_line = '0;
    logic violation;
    logic commit_req = 1'b0;
    logic commit_ack;
    logic abort = 1'b0;

    int n_cmp = 0;
    int n_bad = 0;
    bit finished = 0;

    typedef struct {
        logic [AW-1:0] a;
        logic [DW-1:0] d;
        logic [3:0]    be;
        string         req;
    } wr_t;
    wr_t exp_q[$];

    spec_store_buffer #(
        .DEPTH(DEPTH), .ADDR_W(AW), .DATA_W(DW), .LINE_BYTES(LB), .AGE_LIMIT(AGE)
    ) uut (
        .clk(clk), .rst_n(rst_n),
        .st_valid(st_valid), .st_addr(st_addr), .st_data(st_data), .st_be(st_be),
        .st_spec(st_spec), .st_ready(st_ready),
        .wr_req(wr_req), .wr_addr(wr_addr), .wr_data(wr_data), .wr_be(wr_be),
        .wr_grant(wr_grant), .line_hit(line_hit),
        .ld_word(ld_word), .ld_fwd_data(ld_fwd_data), .ld_fwd_be(ld_fwd_be),
        .snp_valid(snp_valid), .snp_line(snp_line), .violation(violation),
        .commit_req(commit_req), .commit_ack(commit_ack), .abort(abort)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic expect_wr(input logic [AW-1:0] a, input logic [DW-1:0] d,
                             input logic [3:0] be, input string req);
        wr_t e;
        e.a = a; e.d = d; e.be = be; e.req = req;
        exp_q.push_back(e);
    endtask

    // Driver: offer one store for one cycle; starts and ends at a falling edge
    task automatic store(input logic [AW-1:0] a, input logic [DW-1:0] d,
                         input logic [3:0] be, input logic sp);
        st_valid = 1'b1; st_addr = a; st_data = d; st_be = be; st_spec = sp;
        @(negedge clk);
        st_valid = 1'b0;
    endtask

    // Driver: grant for one cycle with a given hit vector
    task automatic grant_cycle(input logic [DEPTH-1:0] hv);
        line_hit = hv; wr_grant = 1'b1;
        @(negedge clk);
        wr_grant = 1'b0;
    endtask

    // Monitor: compare every accepted cache write with the scoreboard
    always @(negedge clk) begin
        #2;
        if (rst_n && wr_req && wr_grant) begin
            if (exp_q.size() == 0) begin
                n_cmp++; n_bad++;
                $display("FAIL R2: actual write %0h expected no write", wr_addr);
            end else begin
                wr_t e;
                e = exp_q.pop_front();
                check({e.req, " wr_addr"}, 64'(wr_addr), 64'(e.a));
                check({e.req, " wr_data"}, 64'(wr_data), 64'(e.d));
                check({e.req, " wr_be"},   64'(wr_be),   64'(e.be));
            end
        end
    end

    // Watchdog
    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        #1;
        // R1: reset state
        commit_req = 1'b1; snp_valid = 1'b1; snp_line = 28'h10; ld_word = 30'h40;
        #1;
        check("R1 st_ready", 64'(st_ready), 64'd1);
        check("R1 wr_req", 64'(wr_req), 64'd0);
        check("R1 ld_fwd_be", 64'(ld_fwd_be), 64'd0);
        check("R1 commit_ack", 64'(commit_ack), 64'd1);
        check("R8 no entry no violation", 64'(violation), 64'd0);
        commit_req = 1'b0; snp_valid = 1'b0;
        @(negedge clk);

        // R2/R3/R4: fill, refuse when full, drain hit-first then oldest
        line_hit = '1;
        store(32'h100, 32'hA0A0A0A0, 4'hF, 1'b0);
        store(32'h204, 32'hA1A1A1A1, 4'hF, 1'b0);
        store(32'h308, 32'hA2A2A2A2, 4'hF, 1'b0);
        store(32'h40C, 32'hA3A3A3A3, 4'hF, 1'b0);
        #1;
        check("R2 full st_ready", 64'(st_ready), 64'd0);
        store(32'h500, 32'hDEADBEEF, 4'hF, 1'b0);
        expect_wr(32'h308, 32'hA2A2A2A2, 4'hF, "R3 hit first");
        expect_wr(32'h40C, 32'hA3A3A3A3, 4'hF, "R3 next hit");
        expect_wr(32'h100, 32'hA0A0A0A0, 4'hF, "R4 oldest miss");
        expect_wr(32'h204, 32'hA1A1A1A1, 4'hF, "R4 younger miss");
        grant_cycle(4'b0100);
        grant_cycle(4'b1000);
        grant_cycle(4'b0000);
        grant_cycle(4'b0000);
        #1;
        check("R2 dropped store absent", 64'(wr_req), 64'd0);
        check("R2 queue consumed", 64'(exp_q.size()), 64'd0);
        @(negedge clk);

        // R5: two misses age past a hitting entry
        line_hit = '1;
        store(32'h600, 32'hB0B0B0B0, 4'hF, 1'b0);
        store(32'h704, 32'hB1B1B1B1, 4'hF, 1'b0);
        store(32'h808, 32'hB2B2B2B2, 4'hF, 1'b0);
        line_hit = 4'b0010;
        repeat (AGE + 1) @(negedge clk);
        expect_wr(32'h600, 32'hB0B0B0B0, 4'hF, "R5 aged oldest");
        expect_wr(32'h808, 32'hB2B2B2B2, 4'hF, "R5 aged beats hit");
        expect_wr(32'h704, 32'hB1B1B1B1, 4'hF, "R5 hit after aged");
        grant_cycle(4'b0010);
        grant_cycle(4'b0010);
        grant_cycle(4'b0010);
        #1;
        check("R5 drained", 64'(wr_req), 64'd0);
        @(negedge clk);

        // R6/R7: same-word ordering and byte-merged forwarding
        line_hit = '1;
        store(32'h900, 32'h11111111, 4'hF, 1'b0);
        store(32'h904, 32'h22222222, 4'hF, 1'b0);
        store(32'h900, 32'h00003333, 4'h3, 1'b0);
        ld_word = 30'h240;
        #1;
        check("R7 merged data", 64'(ld_fwd_data), 64'h11113333);
        check("R7 merged lanes", 64'(ld_fwd_be), 64'hF);
        ld_word = 30'h241;
        #1;
        check("R7 other word", 64'(ld_fwd_data), 64'h22222222);
        ld_word = 30'h280;
        #1;
        check("R7 no match lanes", 64'(ld_fwd_be), 64'h0);
        @(negedge clk);
        expect_wr(32'h900, 32'h11111111, 4'hF, "R6 older same word first");
        expect_wr(32'h900, 32'h00003333, 4'h3, "R6 younger same word second");
        expect_wr(32'h904, 32'h22222222, 4'hF, "R4 remaining miss");
        grant_cycle(4'b0100);
        grant_cycle(4'b0100);
        grant_cycle(4'b0100);
        @(negedge clk);

        // R8/R9/R10: snoop, commit and abort with mixed entries
        line_hit = '1;
        store(32'hB00, 32'hC0C0C0C0, 4'hF, 1'b0);
        store(32'hC10, 32'hC1C1C1C1, 4'hF, 1'b1);
        store(32'hD20, 32'hC2C2C2C2, 4'hF, 1'b1);
        snp_valid = 1'b1; snp_line = 28'hC1;
        #1;
        check("R8 speculative line hit", 64'(violation), 64'd1);
        snp_line = 28'hB0;
        #1;
        check("R8 ordinary line ignored", 64'(violation), 64'd0);
        snp_valid = 1'b0; snp_line = 28'hD2;
        #1;
        check("R8 no request", 64'(violation), 64'd0);
        commit_req = 1'b1;
        #1;
        check("R9 commit held", 64'(commit_ack), 64'd0);
        @(negedge clk);
        abort = 1'b1;
        @(negedge clk);
        abort = 1'b0;
        #1;
        check("R10 commit after abort", 64'(commit_ack), 64'd1);
        snp_valid = 1'b1; snp_line = 28'hC1;
        #1;
        check("R10 speculative entry gone", 64'(violation), 64'd0);
        snp_valid = 1'b0;
        ld_word = 30'h2C0;
        #1;
        check("R10 ordinary entry kept", 64'(ld_fwd_data), 64'hC0C0C0C0);
        ld_word = 30'h304;
        #1;
        check("R10 speculative lanes gone", 64'(ld_fwd_be), 64'h0);
        @(negedge clk);
        expect_wr(32'hB00, 32'hC0C0C0C0, 4'hF, "R10 ordinary drains");
        grant_cycle(4'b1111);
        #1;
        check("R10 only ordinary drained", 64'(wr_req), 64'd0);
        @(negedge clk);
        store(32'hE00, 32'hE0E0E0E0, 4'hF, 1'b1);
        #1;
        check("R9 speculative pending", 64'(commit_ack), 64'd0);
        @(negedge clk);
        expect_wr(32'hE00, 32'hE0E0E0E0, 4'hF, "R9 speculative drains");
        grant_cycle(4'b1111);
        #1;
        check("R9 commit after drain", 64'(commit_ack), 64'd1);
        commit_req = 1'b0;
        repeat (2) @(negedge clk);
        check("R2 scoreboard empty", 64'(exp_q.size()), 64'd0);

        finished = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule